// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

This block drives two pulse-width-modulated digital outputs from a single time base. A programmable prescaler divides the input clock by its reload value plus one. Each time the prescaler wraps, it advances an 8-bit period counter that runs from 0 to 254 and then returns to 0. The period is therefore 255 counts long. Each channel compares its own compare register with that shared counter. Its output is LOW while the compare value is greater than the count, and HIGH otherwise. Both channels share the prescaler and the counter, so they always repeat at the same rate.

A simple register port programs the block. One single-cycle write strobe selects a register with a 2-bit address and loads it with the write data. A combinational read path returns the selected register. A new compare value steers its output from the next clock, with no wait for the period to end. A new prescaler reload value waits for the next prescaler wrap. The running prescaler count is never cleared by a write and cannot be read.

Top module: `pwm_dual`

## Requirements
- R1: After a synchronous reset the reload register and both compare registers read 00H, the counter is 0 and both outputs are HIGH.
- R2: With an active reload value P, the counter advances by one once every P+1 clocks. With P = 0 it advances on every clock.
- R3: The counter steps through 0 to 254 and wraps from 254 to 0. It never holds 255.
- R4: Output n (pwm_out[n]) is LOW exactly when compare register n is strictly greater than the counter, and HIGH otherwise. Over any 255 consecutive counter steps, output n is HIGH for 255 minus its compare value of them.
- R5: Compare value 00H gives a constant HIGH output. Compare value FFH gives a constant LOW output.
- R6: A compare write (address 1 for channel 0, address 2 for channel 1) governs its output from the clock after the write edge. It is not held back to the end of the period.
- R7: A write to the reload register (address 0) becomes the active divider at the next prescaler wrap. The running prescaler count is not reset by the write.
- R8: rdata returns the reload value at address 0, compare 0 at address 1 and compare 1 at address 2. Address 3 reads 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | Register select: 0 reload, 1 compare 0, 2 compare 1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register chosen by addr |
| pwm_out | output | 2 | PWM outputs, bit n for channel n |

## Verification
The assertions assume that wr_en and addr are never unknown at a clock edge. They also assume that reset is held across at least one edge before any check counts. The stimulus meets these assumptions as follows:
- It changes every input one time unit after a falling edge, so inputs are stable at each rising edge.
- It raises wr_en for exactly one cycle per write.
- It uses only the four decoded addresses.
- It holds reset for several cycles at the start.

Because every address is valid, no assertion has to reason about an undecoded write.

// File: rtl/pwm_dual.sv
module pwm_dual #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [1:0]   pwm_out
);
  localparam logic [W-1:0] TOP = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] reload_q, act_q, pre_q, cnt_q;
  logic [W-1:0] cmp_q [2];
  logic         tick;

  assign tick = (pre_q == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      act_q    <= '0;
      pre_q    <= '0;
      cnt_q    <= '0;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
    end else begin
      if (tick) begin
        pre_q <= '0;
        act_q <= reload_q;
        cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
      if (wr_en) begin
        case (addr)
          2'd0:    reload_q <= wdata;
          2'd1:    cmp_q[0] <= wdata;
          2'd2:    cmp_q[1] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = reload_q;
      2'd1:    rdata = cmp_q[0];
      2'd2:    rdata = cmp_q[1];
      default: rdata = '0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    assign pwm_out[g] = (cmp_q[g] <= cnt_q);
  end
endmodule

// File: rtl/pwm_dual_chk.sv
module pwm_dual_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [W-1:0] pre,
  input logic [W-1:0] act,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] cmp1,
  input logic [1:0]   pwm
);
  localparam logic [W-1:0] TOP  = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt != ONES);
  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == TOP) |=> cnt == '0);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst) pre <= act);
  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act));
  // R5
  ff_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp0 == ONES) |-> !pwm[0]);
  // R5
  zero_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp1 == '0) |-> pwm[1]);
endmodule

bind pwm_dual pwm_dual_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt(cnt_q), .pre(pre_q), .act(act_q),
  .cmp0(cmp_q[0]), .cmp1(cmp_q[1]), .pwm(pwm_out)
);

// File: tb/pwm_dual_test.sv
module pwm_dual_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [1:0] pwm_out;

  int vectors = 0;
  int fails   = 0;
  int m_pre = 0, m_act = 0, m_pc = 0, m_cnt = 0;
  int m_cmp0 = 0, m_cmp1 = 0;
  bit model_on = 0;
  string cur_req = "R2";

  pwm_dual uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= 0; m_act <= 0; m_pc <= 0; m_cnt <= 0; m_cmp0 <= 0; m_cmp1 <= 0;
    end else begin
      if (m_pc == m_act) begin
        m_pc  <= 0;
        m_act <= m_pre;
        m_cnt <= (m_cnt + 1) % 255;
      end else m_pc <= m_pc + 1;
      if (wr_en) begin
        if (addr == 0) m_pre  <= wdata;
        if (addr == 1) m_cmp0 <= wdata;
        if (addr == 2) m_cmp1 <= wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      logic [1:0] e;
      e = {m_cmp1 <= m_cnt, m_cmp0 <= m_cnt};
      vectors++;
      if (pwm_out !== e) begin
        fails++;
        $display("FAIL %s: pwm_out=%b expected %b (cnt %0d)", cur_req, pwm_out, e, m_cnt);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    @(negedge clk); #1; addr = a; #1;
    vectors++;
    if (rdata !== 8'(exp)) begin
      fails++;
      $display("FAIL %s: rdata[%0d]=%0d expected %0d", req, a, rdata, exp);
    end
  endtask

  task automatic duty_chk(input int ch, input int cmp, input string req);
    int highs = 0;
    repeat (255) begin
      @(negedge clk);
      highs += pwm_out[ch];
    end
    vectors++;
    if (highs != 255 - cmp) begin
      fails++;
      $display("FAIL %s: ch%0d cmp %0d high count %0d expected %0d", req, ch, cmp, highs, 255 - cmp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    int cmps[8] = '{0, 1, 2, 127, 128, 253, 254, 255};
    repeat (4) @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    vectors++;
    if (pwm_out !== 2'b11) begin
      fails++;
      $display("FAIL R1: pwm_out=%b expected 11", pwm_out);
    end
    rd_chk(0, 0, "R1"); rd_chk(1, 0, "R1"); rd_chk(2, 0, "R1");
    model_on = 1;

    cur_req = "R3";
    repeat (600) @(negedge clk);

    cur_req = "R4";
    foreach (cmps[i]) begin
      wr(1, 8'(cmps[i]));
      wr(2, 8'(cmps[7 - i]));
      rd_chk(1, cmps[i], "R8");
      rd_chk(2, cmps[7 - i], "R8");
      duty_chk(0, cmps[i], (cmps[i] == 0 || cmps[i] == 255) ? "R5" : "R4");
      duty_chk(1, cmps[7 - i], (cmps[i] == 0 || cmps[i] == 255) ? "R5" : "R4");
    end
    rd_chk(3, 0, "R8");

    cur_req = "R6";
    for (int k = 0; k < 40; k++) begin
      wr(1, 8'(k * 7));
      wr(2, 8'(255 - k * 5));
      repeat (3) @(negedge clk);
    end

    cur_req = "R2";
    wr(0, 8'd2);
    rd_chk(0, 2, "R8");
    wr(1, 8'd100);
    wr(2, 8'd30);
    repeat (1600) @(negedge clk);

    cur_req = "R7";
    for (int p = 0; p < 6; p++) begin
      wr(0, 8'(p * 3 + 1));
      repeat (50 + p) @(negedge clk);
    end
    wr(0, 8'd9);
    repeat (3) @(negedge clk);
    wr(0, 8'd0);
    repeat (2600) @(negedge clk);

    cur_req = "R2";
    wr(0, 8'd0);
    repeat (20) @(negedge clk);
    summary();
  end
endmodule